// File: doc/BRIEF.md
# Two-Plane Coincidence Trigger Unit

The unit receives digitized hit frames from two opposing detector planes, called plane A and plane B. Each frame arrives in a single cycle. It carries a channel identifier, a coarse start time and ten consecutive energy samples. For every frame the unit finds the sample with the largest value and forms a time tag from it. It also forms a signed sub-sample offset (delta) from the peak and its two neighbours, and an energy value with the baseline removed. Hits whose energy is below a programmable threshold are dropped at once.

Each plane keeps one pending hit. When both planes hold a hit, the unit compares their fine times. A fine time is the time tag in sixteenths of a sample plus delta. If the two fine times lie within the programmed window, the unit issues a trigger. The trigger names both hits and tells the acquisition side to release their buffered data. If the hits do not pair, the older one is discarded immediately. The newer one waits for a partner.

The trigger leaves through a valid/ready port. When the port is always ready, each trigger is a single-cycle valid pulse. When the readout side stalls, the trigger and the pair queued behind it are held.

Top module: `coinc_trigger_top`

## Requirements
- R1: While rst_n is low, trig_valid is 0. Reset empties both pending-hit slots and any held trigger, so a lone hit after reset produces no trigger.
- R2: The time tag of a hit is the frame start time plus the index (0 to 9) of its largest sample. When several samples share the largest value, the lowest index wins.
- R3: Delta is a 4-bit two's-complement value in sixteenths of a sample, computed from left neighbour L, peak P and right neighbour R. Let D = 2P-L-R and N = |R-L|. Q counts the k in 1..8 with 16*N >= (2k-1)*D. Delta is -Q when L > R, and otherwise the smaller of Q and 7. Delta is 0 when the peak is at index 0 or 9, or when D = 0.
- R4: Hit energy is the sum of the ten samples minus ten times cfg_baseline, floored at 0. A hit is kept when its energy is at least cfg_e_thresh and is dropped otherwise.
- R5: Two pending hits pair when |(tagA*16+deltaA) - (tagB*16+deltaB)| <= cfg_window*16. Equality pairs.
- R6: When frames from both planes are presented in the same cycle and pair, trig_valid rises after the third rising clock edge that follows the frame cycle's start. Exactly three edges are counted from the edge that samples the frames.
- R7: When both slots are occupied and the hits do not pair, the hit with the smaller fine time is discarded and the other stays pending, ready to pair with a later hit.
- R8: A new kept hit on a plane replaces that plane's pending hit.
- R9: While trig_valid is 1 and trig_ready is 0, trig_valid stays 1 and all trigger fields stay unchanged. A pair that matches during the stall is issued in the cycle the held trigger is accepted.
- R10: Issuing a trigger empties both slots, so each hit takes part in at most one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_frm_vld | input | 1 | Plane A frame present this cycle |
| a_frm_id | input | 8 | Plane A channel identifier |
| a_frm_time | input | 16 | Plane A time of sample 0 |
| a_frm_smp | input | 120 | Plane A samples, sample i in bits [12i+11:12i] |
| b_frm_vld | input | 1 | Plane B frame present this cycle |
| b_frm_id | input | 8 | Plane B channel identifier |
| b_frm_time | input | 16 | Plane B time of sample 0 |
| b_frm_smp | input | 120 | Plane B samples, same packing |
| cfg_baseline | input | 12 | Per-sample baseline subtracted from the energy |
| cfg_e_thresh | input | 16 | Minimum energy for a hit to be kept |
| cfg_window | input | 8 | Coincidence half-width in time-tag units |
| trig_valid | output | 1 | Trigger present |
| trig_ready | input | 1 | Readout side accepts the trigger |
| trig_id_a | output | 8 | Plane A hit identifier |
| trig_id_b | output | 8 | Plane B hit identifier |
| trig_tag_a | output | 16 | Plane A time tag |
| trig_tag_b | output | 16 | Plane B time tag |
| trig_dlt_a | output | 4 | Plane A delta, signed sixteenths |
| trig_dlt_b | output | 4 | Plane B delta, signed sixteenths |

## Verification
Every cycle, the assertions check three things. A stalled trigger must hold its valid and its fields. Every issued pair must lie inside the programmed window. A slot must empty after a trigger, and it may fill only two edges after a frame on its plane. The scenarios show what the assertions cannot: the exact peak index on ties, the delta arithmetic, the energy threshold boundary, the discard-older rule and slot replacement. They also show the window edge from both sides and the hand-off of a queued pair when a stall ends.

// File: rtl/coinc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the coincidence trigger unit.
// Assumes: delta is carried in sixteenths of a sample as a 4-bit signed value.
package coinc_pkg;
    localparam int DLT_W   = 4;                 // delta width, two's complement
    localparam int FRAC_SH = 4;                 // fine time = tag << FRAC_SH + delta
    localparam int STEPS   = 1 << (DLT_W - 1);  // magnitude comparisons per delta
endpackage

// File: rtl/peak_locate.sv
`timescale 1ns/1ps
// Finds the largest sample of a frame and returns its index and its two
// neighbours. Assumes unsigned samples; the lowest index wins a tie.
module peak_locate #(
    parameter  int NS  = 10,
    parameter  int SW  = 12,
    localparam int IXW = $clog2(NS)
) (
    input  logic [NS*SW-1:0] smp,
    output logic [IXW-1:0]   idx,
    output logic [SW-1:0]    top,
    output logic [SW-1:0]    left,
    output logic [SW-1:0]    right,
    output logic             has_l,
    output logic             has_r
);
    // Scan for the first strict maximum, then pick its neighbours.
    always_comb begin
        idx = '0;
        top = smp[0 +: SW];
        for (int i = 1; i < NS; i++) begin
            if (smp[i*SW +: SW] > top) begin
                top = smp[i*SW +: SW];
                idx = IXW'(i);
            end
        end
        left  = '0;
        right = '0;
        for (int i = 0; i < NS; i++) begin
            if (i + 1 == int'(idx)) left  = smp[i*SW +: SW];
            if (i == int'(idx) + 1) right = smp[i*SW +: SW];
        end
        has_l = (idx != '0);
        has_r = (idx != IXW'(NS - 1));
    end
endmodule

// File: rtl/subsample_delta.sv
`timescale 1ns/1ps
// Quantized parabolic estimate of the true peak position relative to the
// peak sample, without a divider: a bank of constant-multiple comparisons
// counts how many half-step boundaries the ratio crosses.
// Assumes top >= left and top >= right (top is the frame maximum).
module subsample_delta #(
    parameter int SW = 12
) (
    input  logic [SW-1:0]                   left,
    input  logic [SW-1:0]                   top,
    input  logic [SW-1:0]                   right,
    input  logic                            has_l,
    input  logic                            has_r,
    output logic signed [coinc_pkg::DLT_W-1:0] dlt
);
    import coinc_pkg::*;
    localparam int MW = SW + FRAC_SH + 2;

    logic [MW-1:0]     den, num, num_sc;
    logic              neg;
    logic [STEPS-1:0]  ge;
    logic [DLT_W:0]    cnt;

    // Curvature and asymmetry of the three samples around the peak.
    always_comb begin
        den    = (MW'(top) << 1) - MW'(left) - MW'(right);
        neg    = left > right;
        num    = neg ? (MW'(left) - MW'(right)) : (MW'(right) - MW'(left));
        num_sc = num << FRAC_SH;
    end

    // One comparator per odd half-step boundary.
    for (genvar k = 0; k < STEPS; k++) begin : g_step
        localparam logic [MW-1:0] ODD = MW'(2 * k + 1);
        assign ge[k] = num_sc >= ODD * den;
    end

    assign cnt = (DLT_W + 1)'($countones(ge));

    // Sign, clamp and edge handling.
    always_comb begin
        if (!has_l || !has_r || den == '0)
            dlt = '0;
        else if (neg)
            dlt = -DLT_W'(cnt);
        else if (cnt > (DLT_W + 1)'(STEPS - 1))
            dlt = DLT_W'(STEPS - 1);
        else
            dlt = DLT_W'(cnt);
    end
endmodule

// File: rtl/hit_extract.sv
`timescale 1ns/1ps
// Per-plane front stage: peak search, delta, baseline-corrected energy and
// threshold cut, registered once. Assumes one frame per cycle at most.
module hit_extract #(
    parameter  int NS  = 10,
    parameter  int SW  = 12,
    parameter  int IDW = 8,
    parameter  int TW  = 16,
    localparam int EW  = SW + $clog2(NS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_vld,
    input  logic [IDW-1:0]                    in_id,
    input  logic [TW-1:0]                     in_time,
    input  logic [NS*SW-1:0]                  in_smp,
    input  logic [SW-1:0]                     baseline,
    input  logic [EW-1:0]                     e_thresh,
    output logic                              out_vld,
    output logic [IDW-1:0]                    out_id,
    output logic [TW-1:0]                     out_tag,
    output logic signed [coinc_pkg::DLT_W-1:0] out_dlt
);
    localparam int IXW = $clog2(NS);

    logic [IXW-1:0] pk_idx;
    logic [SW-1:0]  pk_top, pk_l, pk_r;
    logic           pk_hl, pk_hr;
    logic signed [coinc_pkg::DLT_W-1:0] dlt;
    logic [EW-1:0]  sum, base_tot, energy;
    logic           keep;

    peak_locate #(.NS(NS), .SW(SW)) u_peak (
        .smp(in_smp), .idx(pk_idx), .top(pk_top),
        .left(pk_l), .right(pk_r), .has_l(pk_hl), .has_r(pk_hr)
    );

    subsample_delta #(.SW(SW)) u_delta (
        .left(pk_l), .top(pk_top), .right(pk_r),
        .has_l(pk_hl), .has_r(pk_hr), .dlt(dlt)
    );

    // Sum of samples less the total baseline, floored at zero.
    always_comb begin
        sum = '0;
        for (int i = 0; i < NS; i++) sum += EW'(in_smp[i*SW +: SW]);
        base_tot = EW'(baseline) * EW'(NS);
        energy   = (sum > base_tot) ? (sum - base_tot) : '0;
        keep     = energy >= e_thresh;
    end

    // Register the qualified hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_id  <= '0;
            out_tag <= '0;
            out_dlt <= '0;
        end else begin
            out_vld <= in_vld && keep;
            if (in_vld) begin
                out_id  <= in_id;
                out_tag <= in_time + TW'(pk_idx);
                out_dlt <= dlt;
            end
        end
    end
endmodule

// File: rtl/pair_matcher.sv
`timescale 1ns/1ps
// Holds one pending hit per plane, compares fine times against the window,
// issues a trigger through a valid/ready register and discards the older hit
// of a non-matching pair. Assumes per-plane hits arrive in time order and
// that tag differences stay below half the fine-time range.
module pair_matcher #(
    parameter int IDW = 8,
    parameter int TW  = 16,
    parameter int WW  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             in_vld,
    input  logic [IDW-1:0]         in_id  [2],
    input  logic [TW-1:0]          in_tag [2],
    input  logic [coinc_pkg::DLT_W-1:0] in_dlt [2],
    input  logic [WW-1:0]          window,
    output logic                   trig_valid,
    input  logic                   trig_ready,
    output logic [IDW-1:0]         trig_id  [2],
    output logic [TW-1:0]          trig_tag [2],
    output logic [coinc_pkg::DLT_W-1:0] trig_dlt [2]
);
    import coinc_pkg::*;
    localparam int FW = TW + FRAC_SH;

    logic                 slot_vld [2];
    logic [IDW-1:0]       slot_id  [2];
    logic [TW-1:0]        slot_tag [2];
    logic [DLT_W-1:0]     slot_dlt [2];
    logic [FW-1:0]        fine [2];
    logic [FW-1:0]        diff, mag, win_fine;
    logic                 both, hit, dneg, can_push, push;
    logic [1:0]           drop;

    // Fine-time distance and the pair decision.
    always_comb begin
        for (int p = 0; p < 2; p++)
            fine[p] = (FW'(slot_tag[p]) << FRAC_SH) + FW'($signed(slot_dlt[p]));
        diff     = fine[0] - fine[1];
        dneg     = diff[FW-1];
        mag      = dneg ? -diff : diff;
        win_fine = FW'(window) << FRAC_SH;
        both     = slot_vld[0] && slot_vld[1];
        hit      = mag <= win_fine;
        can_push = !trig_valid || trig_ready;
        push     = both && hit && can_push;
        drop[0]  = both && !hit && dneg;
        drop[1]  = both && !hit && !dneg;
    end

    // Slot update: a new hit wins over a clear.
    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (!rst_n) begin
                slot_vld[p] <= 1'b0;
                slot_id[p]  <= '0;
                slot_tag[p] <= '0;
                slot_dlt[p] <= '0;
            end else if (in_vld[p]) begin
                slot_vld[p] <= 1'b1;
                slot_id[p]  <= in_id[p];
                slot_tag[p] <= in_tag[p];
                slot_dlt[p] <= in_dlt[p];
            end else if (push || drop[p]) begin
                slot_vld[p] <= 1'b0;
            end
        end
    end

    // Trigger register with ready/valid hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_valid <= 1'b0;
            for (int p = 0; p < 2; p++) begin
                trig_id[p]  <= '0;
                trig_tag[p] <= '0;
                trig_dlt[p] <= '0;
            end
        end else if (push) begin
            trig_valid <= 1'b1;
            for (int p = 0; p < 2; p++) begin
                trig_id[p]  <= slot_id[p];
                trig_tag[p] <= slot_tag[p];
                trig_dlt[p] <= slot_dlt[p];
            end
        end else if (trig_ready) begin
            trig_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/coinc_trigger_top.sv
`timescale 1ns/1ps
// Two-plane coincidence trigger: one extraction stage per plane feeding a
// shared pair matcher. Frame to trigger is three clock edges.
// Assumes configuration inputs are held steady while hits are in flight.
module coinc_trigger_top #(
    parameter  int NS  = 10,
    parameter  int SW  = 12,
    parameter  int IDW = 8,
    parameter  int TW  = 16,
    parameter  int WW  = 8,
    localparam int EW  = SW + $clog2(NS),
    localparam int DW  = coinc_pkg::DLT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_frm_vld,
    input  logic [IDW-1:0]    a_frm_id,
    input  logic [TW-1:0]     a_frm_time,
    input  logic [NS*SW-1:0]  a_frm_smp,
    input  logic              b_frm_vld,
    input  logic [IDW-1:0]    b_frm_id,
    input  logic [TW-1:0]     b_frm_time,
    input  logic [NS*SW-1:0]  b_frm_smp,
    input  logic [SW-1:0]     cfg_baseline,
    input  logic [EW-1:0]     cfg_e_thresh,
    input  logic [WW-1:0]     cfg_window,
    output logic              trig_valid,
    input  logic              trig_ready,
    output logic [IDW-1:0]    trig_id_a,
    output logic [IDW-1:0]    trig_id_b,
    output logic [TW-1:0]     trig_tag_a,
    output logic [TW-1:0]     trig_tag_b,
    output logic [DW-1:0]     trig_dlt_a,
    output logic [DW-1:0]     trig_dlt_b
);
    logic [1:0]         fr_vld;
    logic [IDW-1:0]     fr_id   [2];
    logic [TW-1:0]      fr_time [2];
    logic [NS*SW-1:0]   fr_smp  [2];
    logic [1:0]         ext_vld;
    logic [IDW-1:0]     ext_id  [2];
    logic [TW-1:0]      ext_tag [2];
    logic [DW-1:0]      ext_dlt [2];
    logic [IDW-1:0]     t_id    [2];
    logic [TW-1:0]      t_tag   [2];
    logic [DW-1:0]      t_dlt   [2];

    // Gather both planes into indexed form.
    assign fr_vld     = {b_frm_vld, a_frm_vld};
    assign fr_id[0]   = a_frm_id;
    assign fr_id[1]   = b_frm_id;
    assign fr_time[0] = a_frm_time;
    assign fr_time[1] = b_frm_time;
    assign fr_smp[0]  = a_frm_smp;
    assign fr_smp[1]  = b_frm_smp;

    for (genvar p = 0; p < 2; p++) begin : g_plane
        logic signed [DW-1:0] dlt_s;
        hit_extract #(.NS(NS), .SW(SW), .IDW(IDW), .TW(TW)) u_ext (
            .clk(clk), .rst_n(rst_n),
            .in_vld(fr_vld[p]), .in_id(fr_id[p]), .in_time(fr_time[p]),
            .in_smp(fr_smp[p]), .baseline(cfg_baseline), .e_thresh(cfg_e_thresh),
            .out_vld(ext_vld[p]), .out_id(ext_id[p]), .out_tag(ext_tag[p]),
            .out_dlt(dlt_s)
        );
        assign ext_dlt[p] = dlt_s;
    end

    pair_matcher #(.IDW(IDW), .TW(TW), .WW(WW)) u_match (
        .clk(clk), .rst_n(rst_n),
        .in_vld(ext_vld), .in_id(ext_id), .in_tag(ext_tag), .in_dlt(ext_dlt),
        .window(cfg_window),
        .trig_valid(trig_valid), .trig_ready(trig_ready),
        .trig_id(t_id), .trig_tag(t_tag), .trig_dlt(t_dlt)
    );

    assign trig_id_a  = t_id[0];
    assign trig_id_b  = t_id[1];
    assign trig_tag_a = t_tag[0];
    assign trig_tag_b = t_tag[1];
    assign trig_dlt_a = t_dlt[0];
    assign trig_dlt_b = t_dlt[1];
endmodule

// File: rtl/coinc_trigger_chk.sv
`timescale 1ns/1ps
// Property checker for coinc_trigger_top, attached by bind.
// Assumes cfg_window is steady while a trigger is visible.
module coinc_trigger_chk #(
    parameter int IDW = 8,
    parameter int TW  = 16,
    parameter int WW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           a_frm_vld,
    input logic           b_frm_vld,
    input logic           trig_valid,
    input logic           trig_ready,
    input logic [IDW-1:0] trig_id_a,
    input logic [IDW-1:0] trig_id_b,
    input logic [TW-1:0]  trig_tag_a,
    input logic [TW-1:0]  trig_tag_b,
    input logic [3:0]     trig_dlt_a,
    input logic [3:0]     trig_dlt_b,
    input logic [WW-1:0]  cfg_window,
    input logic           slot_a,
    input logic           slot_b,
    input logic           push,
    input logic [1:0]     ext_vld
);
    localparam int FW = TW + 4;
    logic [FW-1:0] fa, fb, fd, fm;

    // Distance of the issued pair, rebuilt from the output fields.
    always_comb begin
        fa = (FW'(trig_tag_a) << 4) + FW'($signed(trig_dlt_a));
        fb = (FW'(trig_tag_b) << 4) + FW'($signed(trig_dlt_b));
        fd = fa - fb;
        fm = fd[FW-1] ? -fd : fd;
    end

    // R9
    hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && !trig_ready |=> trig_valid);

    // R9
    hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && !trig_ready |=>
            $stable({trig_id_a, trig_id_b, trig_tag_a, trig_tag_b, trig_dlt_a, trig_dlt_b}));

    // R5
    in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> fm <= (FW'(cfg_window) << 4));

    // R10
    clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !ext_vld[0] |=> !slot_a);

    // R10
    clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !ext_vld[1] |=> !slot_b);

    // R6
    fill_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_a && !$past(slot_a) |-> $past(a_frm_vld, 2));

    // R6
    fill_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_b && !$past(slot_b) |-> $past(b_frm_vld, 2));
endmodule

bind coinc_trigger_top coinc_trigger_chk #(.IDW(IDW), .TW(TW), .WW(WW)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .a_frm_vld(a_frm_vld), .b_frm_vld(b_frm_vld),
    .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_id_a(trig_id_a), .trig_id_b(trig_id_b),
    .trig_tag_a(trig_tag_a), .trig_tag_b(trig_tag_b),
    .trig_dlt_a(trig_dlt_a), .trig_dlt_b(trig_dlt_b),
    .cfg_window(cfg_window),
    .slot_a(u_match.slot_vld[0]), .slot_b(u_match.slot_vld[1]),
    .push(u_match.push), .ext_vld(ext_vld)
);

// File: tb/coinc_trigger_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, expected values from the requirements.
module coinc_trigger_top_tb_top;
    localparam int NS = 10, SW = 12, IDW = 8, TW = 16, WW = 8, EW = 16;
    typedef logic [NS*SW-1:0] frame_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic a_frm_vld = 1'b0, b_frm_vld = 1'b0;
    logic [IDW-1:0] a_frm_id = '0, b_frm_id = '0;
    logic [TW-1:0]  a_frm_time = '0, b_frm_time = '0;
    frame_t         a_frm_smp = '0, b_frm_smp = '0;
    logic [SW-1:0]  cfg_baseline = '0;
    logic [EW-1:0]  cfg_e_thresh = '0;
    logic [WW-1:0]  cfg_window = 8'd4;
    logic           trig_ready = 1'b1;
    logic           trig_valid;
    logic [IDW-1:0] trig_id_a, trig_id_b;
    logic [TW-1:0]  trig_tag_a, trig_tag_b;
    logic [3:0]     trig_dlt_a, trig_dlt_b;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    coinc_trigger_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_frm_vld(a_frm_vld), .a_frm_id(a_frm_id), .a_frm_time(a_frm_time), .a_frm_smp(a_frm_smp),
        .b_frm_vld(b_frm_vld), .b_frm_id(b_frm_id), .b_frm_time(b_frm_time), .b_frm_smp(b_frm_smp),
        .cfg_baseline(cfg_baseline), .cfg_e_thresh(cfg_e_thresh), .cfg_window(cfg_window),
        .trig_valid(trig_valid), .trig_ready(trig_ready),
        .trig_id_a(trig_id_a), .trig_id_b(trig_id_b),
        .trig_tag_a(trig_tag_a), .trig_tag_b(trig_tag_b),
        .trig_dlt_a(trig_dlt_a), .trig_dlt_b(trig_dlt_b)
    );

    // Record one check.
    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Pulse: every sample at flr, peak c at p, neighbours l and r.
    function automatic frame_t pulse(int p, int l, int c, int r, int flr);
        frame_t v;
        for (int i = 0; i < NS; i++) v[i*SW +: SW] = SW'(flr);
        v[p*SW +: SW] = SW'(c);
        if (p > 0)      v[(p-1)*SW +: SW] = SW'(l);
        if (p < NS - 1) v[(p+1)*SW +: SW] = SW'(r);
        return v;
    endfunction

    // R2 model: first index of the largest sample.
    function automatic int m_idx(frame_t v);
        int bi = 0;
        for (int i = 1; i < NS; i++)
            if (v[i*SW +: SW] > v[bi*SW +: SW]) bi = i;
        return bi;
    endfunction

    // R3 model of delta.
    function automatic int m_dlt(frame_t v);
        int i = m_idx(v);
        int l, c, r, d, n, q;
        if (i == 0 || i == NS - 1) return 0;
        l = int'(v[(i-1)*SW +: SW]);
        c = int'(v[i*SW +: SW]);
        r = int'(v[(i+1)*SW +: SW]);
        d = 2 * c - l - r;
        if (d == 0) return 0;
        n = (r > l) ? r - l : l - r;
        q = 0;
        for (int k = 1; k <= 8; k++) if (16 * n >= (2 * k - 1) * d) q++;
        if (l > r) return -q;
        return (q > 7) ? 7 : q;
    endfunction

    task automatic restart(input int win, input int base, input int thr);
        @(negedge clk);
        rst_n = 1'b0; a_frm_vld = 1'b0; b_frm_vld = 1'b0; trig_ready = 1'b1;
        cfg_window = WW'(win); cfg_baseline = SW'(base); cfg_e_thresh = EW'(thr);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present frames for one cycle; returns at the negedge after the sampling edge.
    task automatic send(input bit ea, input int ida, input int ta, input frame_t sa,
                        input bit eb, input int idb, input int tb, input frame_t sb);
        @(negedge clk);
        a_frm_vld = ea; a_frm_id = IDW'(ida); a_frm_time = TW'(ta); a_frm_smp = sa;
        b_frm_vld = eb; b_frm_id = IDW'(idb); b_frm_time = TW'(tb); b_frm_smp = sb;
        @(negedge clk);
        a_frm_vld = 1'b0; b_frm_vld = 1'b0;
    endtask

    task automatic cmp_fields(input string req, input int ida, input int idb, input int taga,
                              input int tagb, input int dla, input int dlb);
        chk({req, " id_a"},  int'(trig_id_a), ida);
        chk({req, " id_b"},  int'(trig_id_b), idb);
        chk({req, " tag_a"}, int'(trig_tag_a), taga);
        chk({req, " tag_b"}, int'(trig_tag_b), tagb);
        chk({req, " dlt_a"}, int'($signed(trig_dlt_a)), dla);
        chk({req, " dlt_b"}, int'($signed(trig_dlt_b)), dlb);
    endtask

    task automatic expect_trig(input string req, input int ida, input int idb, input int taga,
                               input int tagb, input int dla, input int dlb);
        for (int k = 0; k < 8; k++) begin
            if (trig_valid) begin
                cmp_fields(req, ida, idb, taga, tagb, dla, dlb);
                @(negedge clk);
                return;
            end
            @(negedge clk);
        end
        chk({req, " trigger seen"}, 0, 1);
    endtask

    task automatic expect_none(input string req, input int cycles);
        int seen = 0;
        for (int k = 0; k < cycles; k++) begin
            if (trig_valid) seen = 1;
            @(negedge clk);
        end
        chk({req, " no trigger"}, seen, 0);
    endtask

    // R2 R3 R6: basic pair with exact latency.
    task automatic t_basic();
        frame_t sa = pulse(4, 100, 200, 150, 5);
        frame_t sb = pulse(3, 150, 200, 100, 5);
        restart(4, 0, 0);
        chk("R1 trig_valid after reset", int'(trig_valid), 0);
        send(1, 8'h11, 1000, sa, 1, 8'h22, 1001, sb);
        @(negedge clk);
        chk("R6 not before third edge", int'(trig_valid), 0);
        @(negedge clk);
        chk("R6 valid at third edge", int'(trig_valid), 1);
        cmp_fields("R2 R3 basic", 8'h11, 8'h22, 1000 + m_idx(sa), 1001 + m_idx(sb),
                   m_dlt(sa), m_dlt(sb));
        chk("R3 positive delta value", m_dlt(sa), 3);
    endtask

    // R2 ties, R3 edge and flat cases.
    task automatic t_ties_edges();
        frame_t sa = pulse(2, 50, 300, 250, 5);
        frame_t sb = pulse(9, 290, 300, 0, 5);
        frame_t sc = pulse(0, 0, 300, 299, 5);
        frame_t sd = pulse(0, 7, 7, 7, 7);
        sa[7*SW +: SW] = SW'(300);
        restart(4, 0, 0);
        send(1, 1, 2000, sa, 1, 2, 1995, sb);
        expect_trig("R2 tie lowest index, R3 edge", 1, 2, 2002, 2004, 5, 0);
        send(1, 3, 3000, sc, 1, 4, 3000, sd);
        expect_trig("R3 index0 and flat", 3, 4, 3000, 3000, 0, 0);
    endtask

    // R4: energy threshold boundary and floor at zero.
    task automatic t_threshold();
        frame_t s = pulse(5, 60, 100, 60, 10);
        restart(4, 10, 190);
        send(1, 5, 400, s, 1, 6, 400, s);
        expect_trig("R4 energy equal to threshold kept", 5, 6, 405, 405, 0, 0);
        restart(4, 10, 191);
        send(1, 5, 400, s, 1, 6, 400, s);
        expect_none("R4 energy below threshold dropped", 6);
        restart(4, 200, 0);
        send(1, 7, 400, s, 1, 8, 400, s);
        expect_trig("R4 floored energy meets zero threshold", 7, 8, 405, 405, 0, 0);
        restart(4, 200, 1);
        send(1, 7, 400, s, 1, 8, 400, s);
        expect_none("R4 floored energy below one", 6);
    endtask

    // R5: window edge from both sides.
    task automatic t_window();
        frame_t sym = pulse(4, 100, 200, 100, 5);
        frame_t pos = pulse(4, 100, 200, 120, 5);
        restart(2, 0, 0);
        send(1, 1, 96, sym, 1, 2, 98, sym);
        expect_trig("R5 distance equal to window", 1, 2, 100, 102, 0, 0);
        chk("R5 delta plus one", m_dlt(pos), 1);
        restart(2, 0, 0);
        send(1, 1, 96, sym, 1, 2, 98, pos);
        expect_none("R5 one sixteenth beyond window", 6);
        restart(2, 0, 0);
        send(1, 3, 98, sym, 1, 4, 96, sym);
        expect_trig("R5 window with B earlier", 3, 4, 102, 100, 0, 0);
    endtask

    // R7: older unmatched hit discarded, newer waits.
    task automatic t_discard();
        frame_t sym = pulse(4, 100, 200, 100, 5);
        restart(4, 0, 0);
        send(1, 1, 96, sym, 0, 0, 0, '0);
        send(0, 0, 0, '0, 1, 2, 496, sym);
        expect_none("R7 distant pair", 6);
        send(1, 3, 498, sym, 0, 0, 0, '0);
        expect_trig("R7 newer hit kept", 3, 2, 502, 500, 0, 0);
    endtask

    // R8: replacement on the same plane.
    task automatic t_replace();
        frame_t sym = pulse(4, 100, 200, 100, 5);
        restart(4, 0, 0);
        send(1, 1, 96, sym, 0, 0, 0, '0);
        send(1, 4, 296, sym, 0, 0, 0, '0);
        send(0, 0, 0, '0, 1, 5, 297, sym);
        expect_trig("R8 replaced hit pairs", 4, 5, 300, 301, 0, 0);
    endtask

    // R9 R10: stall holds the trigger, queued pair follows, slots cleared.
    task automatic t_backpressure();
        frame_t sym = pulse(4, 100, 200, 100, 5);
        restart(4, 0, 0);
        trig_ready = 1'b0;
        send(1, 7, 46, sym, 1, 8, 47, sym);
        repeat (3) @(negedge clk);
        chk("R9 held valid", int'(trig_valid), 1);
        send(1, 9, 66, sym, 1, 10, 66, sym);
        repeat (3) @(negedge clk);
        chk("R9 held valid under queued pair", int'(trig_valid), 1);
        cmp_fields("R9 stable payload", 7, 8, 50, 51, 0, 0);
        trig_ready = 1'b1;
        @(negedge clk);
        chk("R9 queued pair follows", int'(trig_valid), 1);
        cmp_fields("R9 queued payload", 9, 10, 70, 70, 0, 0);
        @(negedge clk);
        chk("R9 accepted", int'(trig_valid), 0);
        send(0, 0, 0, '0, 1, 11, 66, sym);
        expect_none("R10 slots empty after trigger", 6);
    endtask

    // R1: reset clears a held trigger and pending hits.
    task automatic t_reset();
        frame_t sym = pulse(4, 100, 200, 100, 5);
        restart(4, 0, 0);
        trig_ready = 1'b0;
        send(1, 1, 96, sym, 1, 2, 96, sym);
        send(1, 3, 196, sym, 0, 0, 0, '0);
        repeat (2) @(negedge clk);
        chk("R1 held before reset", int'(trig_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 valid low in reset", int'(trig_valid), 0);
        rst_n = 1'b1; trig_ready = 1'b1;
        @(negedge clk);
        send(0, 0, 0, '0, 1, 4, 196, sym);
        expect_none("R1 pending hit cleared", 6);
    endtask

    initial begin
        t_basic();
        t_ties_edges();
        t_threshold();
        t_window();
        t_discard();
        t_replace();
        t_backpressure();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule